// File: doc/BRIEF.md
# Endianness-Converting Memory Access Adapter

This block sits between a 32-bit processor core and a 32-bit memory port whose byte lanes are little-endian. For each access from the core (instruction fetch, data load or store, or translation-table walk) it produces the memory byte address, the four lane enables and the lane-positioned write data. It also returns the read data right-justified in the order the core expects. The access path is purely combinational. Only the endianness control state is registered.

Two big-endian models are available. In the address-remapping model, byte and halfword addresses are altered and data is not reordered. This model applies to every access class and is enabled by bit 7 of a control word, which only a privileged write may change. In the byte-reversing model, addresses are left alone and the bytes of 16-bit and 32-bit values are reversed. Each access class takes its own enable for this model. Data accesses follow a current data-endian flag, which an unprivileged set-endian command can change and which is reloaded from an exception-endian bit on exception entry. Table walks follow the exception-endian bit directly. Fetches follow an instruction-reversal flag that is sampled from a strap pin while reset is held.

If both models are enabled at once, address remapping wins and a sticky configuration-error output is raised. Misaligned accesses raise an alignment fault and issue nothing.

Top module: `endian_adapter`

## Requirements
- R1: After reset both big-endian models are off and `cfg_error` is 0. Each access then uses memory lane `acc_addr[1:0]`, `mem_addr` equals `acc_addr`, and data is not reordered. Byte enables are `0001<<lane` for a byte, `0011<<lane` for a halfword and `1111` for a word. Write data is shifted left by 8*lane. Read data is the memory word shifted right by 8*lane, then masked to 8 or 16 bits.
- R2: With address remapping on, the low two address bits are XORed with 2'b11 for byte accesses and with 2'b10 for halfword accesses. Word accesses are unchanged. No data reordering is applied. This holds for fetch (class 0), data (class 1) and walk (class 2) accesses alike.
- R3: A cycle with `ctl_wr`=1 and `ctl_priv`=1 loads the address-remapping enable from `ctl_wdata[7]` and the exception-endian bit from `ctl_wdata[9]`. A write with `ctl_priv`=0 changes neither.
- R4: The byte-reversing model affects only halfword and word values. A halfword has its two bytes swapped and a word has its four bytes reversed, on both write and read. Byte accesses and the address are unchanged. Data accesses use it when the current data-endian flag is 1.
- R5: `setend_valid` loads the data-endian flag from `setend_big`, with no privilege required. `exc_entry` reloads the flag from the exception-endian bit and takes precedence over `setend_valid` in the same cycle.
- R6: Table-walk accesses (class 2) use byte reversal exactly when the exception-endian bit is 1, whatever the data-endian flag is.
- R7: The instruction-reversal flag is captured from `strap_irev` while `rst_n` is 0 and is frozen afterwards. Fetches (class 1 is data, class 0 is fetch) are byte-reversed exactly when this flag is 1.
- R8: In either big-endian model, a word store of 0x12345678 followed by a byte load from the same address returns 0x12.
- R9: When the remapping enable and the data-endian flag are both 1 at a clock edge, `cfg_error` becomes 1 from the next cycle and stays 1 until reset. While remapping is on, no byte reversal is applied to any class.
- R10: Sizes are encoded 0 byte, 1 halfword, 2 word, and 3 is reserved. A halfword with `acc_addr[0]`=1, a word with nonzero `acc_addr[1:0]`, or size 3 raises `align_fault`. Such an access keeps `mem_valid` at 0 and returns `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_irev | input | 1 | Instruction-reversal strap, sampled during reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_priv | input | 1 | Control write is privileged |
| ctl_wdata | input | 32 | Control word: bit 7 remap enable, bit 9 exception-endian |
| setend_valid | input | 1 | Set-endian command strobe |
| setend_big | input | 1 | Set-endian value (1 = big) |
| exc_entry | input | 1 | Exception-entry strobe |
| acc_valid | input | 1 | Access request |
| acc_class | input | 2 | 0 fetch, 1 data, 2 walk (3 behaves as data) |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | AW | Byte address from the core |
| acc_wdata | input | 32 | Right-justified write data |
| mem_valid | output | 1 | Memory access issued |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory byte address after remapping |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Lane-positioned write data |
| mem_rdata | input | 32 | Memory read word |
| rd_data | output | 32 | Right-justified read data to the core |
| align_fault | output | 1 | Misaligned or reserved-size access |
| cfg_error | output | 1 | Sticky both-models-enabled flag |

## Verification
The in-RTL assertions check on every cycle the following behaviours:
- The privilege gate on the remap enable, and the exception reload and set-endian updates of the data flag.
- The freezing of the strap flag after reset, and the stickiness of the configuration error.
- Issued accesses are naturally aligned, and words always enable all lanes.
- Addresses pass through untouched when remapping is off, and remapping suppresses data reordering.

The actual lane chosen for each size and mode, the byte order of returned data, the per-class choice of enable source, and the store-then-byte-load result can only be shown by the bench. It does this by comparing every access against its reference functions over random and directed scenarios.

// File: rtl/endian_pkg.sv
// Shared encodings and helpers for the endianness adapter.
// Assumes a 32-bit data path with four byte lanes.
package endian_pkg;
    localparam int DW          = 32;
    localparam int LANES       = DW / 8;
    localparam int CTL_REMAP_B = 7;   // remap enable position in control word
    localparam int CTL_EXCE_B  = 9;   // exception-endian position in control word

    typedef enum logic [1:0] {
        CLS_FETCH = 2'd0,
        CLS_DATA  = 2'd1,
        CLS_WALK  = 2'd2,
        CLS_RSVD  = 2'd3
    } acc_class_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Reverse the byte order of a full data word.
    function automatic logic [DW-1:0] rev_bytes(input logic [DW-1:0] d);
        logic [DW-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[8*i +: 8] = d[8*(LANES-1-i) +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/endian_ctrl.sv
// Endianness control state: remap enable, exception-endian bit,
// current data-endian flag and the strapped instruction-reversal flag.
// Also keeps the sticky configuration-error flag.
// Assumes at most one meaningful command per cycle; exception entry wins.
module endian_ctrl
    import endian_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_irev,
    input  logic          ctl_wr,
    input  logic          ctl_priv,
    input  logic          ctl_remap_bit,
    input  logic          ctl_exce_bit,
    input  logic          setend_valid,
    input  logic          setend_big,
    input  logic          exc_entry,
    output logic          remap_en,
    output logic          exce_en,
    output logic          data_big,
    output logic          irev_en,
    output logic          cfg_err
);
    // Privileged control word updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_en <= 1'b0;
            exce_en  <= 1'b0;
        end else if (ctl_wr && ctl_priv) begin
            remap_en <= ctl_remap_bit;
            exce_en  <= ctl_exce_bit;
        end
    end

    // Data-endian flag: exception reload has precedence over set-endian.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_big <= 1'b0;
        end else if (exc_entry) begin
            data_big <= exce_en;
        end else if (setend_valid) begin
            data_big <= setend_big;
        end
    end

    // Strap capture while reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irev_en <= strap_irev;
        end
    end

    // Sticky flag for both big-endian models enabled at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (remap_en && data_big) begin
            cfg_err <= 1'b1;
        end
    end

    AST_REMAP_PRIV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && ctl_priv) |=> $stable(remap_en)); // R3
    AST_EXC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> (data_big == $past(exce_en))); // R5
    AST_SETEND_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (setend_valid && !exc_entry) |=> (data_big == $past(setend_big))); // R5
    AST_IREV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(irev_en)); // R7
    AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R9
endmodule

// File: rtl/endian_lane_map.sv
// Write-side lane mapper: alignment check, address remap for sub-word
// accesses, optional byte reversal of the value, lane enables and shifts.
// Purely combinational; remap and reversal are assumed mutually exclusive
// (the caller clears swap_en when remap_en is set).
module endian_lane_map
    import endian_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          remap_en,
    input  logic          swap_en,
    input  logic [1:0]    size,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [1:0]    lane,
    output logic          fault,
    output logic [LANES-1:0] be,
    output logic [DW-1:0] wdata_out
);
    logic [DW-1:0] sized;

    // Lane selection, enables and alignment per access size.
    always_comb begin
        fault = 1'b0;
        lane  = addr[1:0];
        be    = '0;
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                lane = remap_en ? (addr[1:0] ^ 2'b11) : addr[1:0];
                be   = 4'b0001 << lane;
            end
            SZ_HALF: begin
                fault = addr[0];
                lane  = remap_en ? (addr[1:0] ^ 2'b10) : addr[1:0];
                be    = 4'b0011 << lane;
            end
            SZ_WORD: begin
                fault = |addr[1:0];
                be    = '1;
            end
            default: fault = 1'b1;
        endcase
    end

    // Value ordering before lane positioning.
    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: sized = {24'd0, wdata[7:0]};
            SZ_HALF: sized = swap_en ? {16'd0, wdata[7:0], wdata[15:8]}
                                     : {16'd0, wdata[15:0]};
            default: sized = swap_en ? rev_bytes(wdata) : wdata;
        endcase
    end

    assign wdata_out = sized << {lane, 3'b000};
endmodule

// File: rtl/endian_read_align.sv
// Read-side aligner: picks the addressed lanes from the memory word,
// right-justifies them and restores core byte order when reversal is on.
// Purely combinational; returns zero for a faulted access.
module endian_read_align
    import endian_pkg::*;
(
    input  logic [1:0]    lane,
    input  logic [1:0]    size,
    input  logic          swap_en,
    input  logic          fault,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] shifted;

    assign shifted = mem_rdata >> {lane, 3'b000};

    // Mask and reorder the selected lanes.
    always_comb begin
        if (fault) begin
            rd_data = '0;
        end else begin
            unique case (acc_size_e'(size))
                SZ_BYTE: rd_data = {24'd0, shifted[7:0]};
                SZ_HALF: rd_data = swap_en ? {16'd0, shifted[7:0], shifted[15:8]}
                                           : {16'd0, shifted[15:0]};
                default: rd_data = swap_en ? rev_bytes(shifted) : shifted;
            endcase
        end
    end
endmodule

// File: rtl/endian_adapter.sv
// Top of the endianness adapter. Chooses, per access class, whether byte
// reversal applies, lets address remapping override it, and drives the
// little-endian memory port. Access path is combinational; only control
// state is registered. Assumes the memory returns mem_rdata in the same
// cycle as the request.
module endian_adapter
    import endian_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_irev,
    input  logic          ctl_wr,
    input  logic          ctl_priv,
    input  logic [31:0]   ctl_wdata,
    input  logic          setend_valid,
    input  logic          setend_big,
    input  logic          exc_entry,
    input  logic          acc_valid,
    input  logic [1:0]    acc_class,
    input  logic [1:0]    acc_size,
    input  logic          acc_we,
    input  logic [AW-1:0] acc_addr,
    input  logic [31:0]   acc_wdata,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic [31:0]   rd_data,
    output logic          align_fault,
    output logic          cfg_error
);
    logic       remap_en, exce_en, data_big, irev_en;
    logic       class_big, swap_en, fault;
    logic [1:0] lane;
    logic       unused_ctl;

    assign unused_ctl = ^{ctl_wdata[31:CTL_EXCE_B+1], ctl_wdata[CTL_EXCE_B-1:CTL_REMAP_B+1],
                          ctl_wdata[CTL_REMAP_B-1:0]};

    endian_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_irev    (strap_irev),
        .ctl_wr        (ctl_wr),
        .ctl_priv      (ctl_priv),
        .ctl_remap_bit (ctl_wdata[CTL_REMAP_B]),
        .ctl_exce_bit  (ctl_wdata[CTL_EXCE_B]),
        .setend_valid  (setend_valid),
        .setend_big    (setend_big),
        .exc_entry     (exc_entry),
        .remap_en      (remap_en),
        .exce_en       (exce_en),
        .data_big      (data_big),
        .irev_en       (irev_en),
        .cfg_err       (cfg_error)
    );

    // Per-class source of the byte-reversal enable.
    always_comb begin
        unique case (acc_class_e'(acc_class))
            CLS_FETCH: class_big = irev_en;
            CLS_WALK:  class_big = exce_en;
            default:   class_big = data_big;
        endcase
    end

    assign swap_en = class_big && !remap_en;

    endian_lane_map #(.AW(AW)) u_wmap (
        .remap_en  (remap_en),
        .swap_en   (swap_en),
        .size      (acc_size),
        .addr      (acc_addr),
        .wdata     (acc_wdata),
        .lane      (lane),
        .fault     (fault),
        .be        (mem_be),
        .wdata_out (mem_wdata)
    );

    endian_read_align u_ralign (
        .lane      (lane),
        .size      (acc_size),
        .swap_en   (swap_en),
        .fault     (fault),
        .mem_rdata (mem_rdata),
        .rd_data   (rd_data)
    );

    assign align_fault = acc_valid && fault;
    assign mem_valid   = acc_valid && !fault;
    assign mem_we      = mem_valid && acc_we;
    assign mem_addr    = {acc_addr[AW-1:2], lane};

    AST_ISSUED_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((acc_size == 2'd1 && !mem_addr[0]) ||
                       (acc_size == 2'd2 && mem_addr[1:0] == 2'b00) ||
                        acc_size == 2'd0)); // R10
    AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && acc_size == 2'd2) |-> (mem_be == 4'hF)); // R2
    AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !remap_en) |-> (mem_addr == acc_addr)); // R4
    AST_REMAP_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && remap_en && acc_size == 2'd2) |-> (mem_wdata == acc_wdata)); // R9
endmodule

// File: tb/endian_adapter_tb.sv
`timescale 1ns/1ps
module endian_adapter_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          strap_irev, ctl_wr, ctl_priv, setend_valid, setend_big, exc_entry;
    logic [31:0]   ctl_wdata;
    logic          acc_valid, acc_we;
    logic [1:0]    acc_class, acc_size;
    logic [AW-1:0] acc_addr;
    logic [31:0]   acc_wdata, mem_rdata;
    logic          mem_valid, mem_we, align_fault, cfg_error;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata, rd_data;

    int checks = 0;
    int fails  = 0;

    // Reference state
    bit m_remap, m_exce, m_big, m_irev, m_cfg;
    logic [7:0] bank [4];

    always #2.5 clk = ~clk;

    endian_adapter #(.AW(AW)) u_dut (.*);

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] bswap(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic bit ref_swap(input logic [1:0] cls);
        if (m_remap) return 1'b0;
        case (cls)
            2'd0:    return m_irev;
            2'd2:    return m_exce;
            default: return m_big;
        endcase
    endfunction

    function automatic logic [1:0] ref_lane(input logic [1:0] sz, input logic [1:0] a);
        if (!m_remap || sz == 2'd2) return a;
        return (sz == 2'd0) ? (a ^ 2'b11) : (a ^ 2'b10);
    endfunction

    function automatic bit ref_fault(input logic [1:0] sz, input logic [1:0] a);
        return (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a != 2'b00);
    endfunction

    function automatic string tag_of(input logic [1:0] cls, input logic [1:0] sz,
                                     input logic [1:0] a);
        if (ref_fault(sz, a))    return "R10";
        if (m_remap && m_big)    return "R9";
        if (m_remap)             return "R2";
        if (cls == 2'd2)         return "R6";
        if (cls == 2'd0)         return "R7";
        if (m_big && sz != 2'd0) return "R4";
        return "R1";
    endfunction

    task automatic idle();
        ctl_wr = 0; ctl_priv = 0; ctl_wdata = '0;
        setend_valid = 0; setend_big = 0; exc_entry = 0;
        acc_valid = 0; acc_we = 0; acc_class = 2'd1; acc_size = 2'd0;
        acc_addr = '0; acc_wdata = '0; mem_rdata = '0;
    endtask

    // Check combinational outputs, then clock and update the reference.
    task automatic cyc();
        logic [1:0] ln;
        logic [31:0] ew, er, sh;
        logic [3:0] eb;
        bit sw, nb;
        string t;
        #1;
        chk(cfg_error == m_cfg, "R9", "cfg_error", {31'd0, cfg_error}, {31'd0, m_cfg});
        if (acc_valid) begin
            t  = tag_of(acc_class, acc_size, acc_addr[1:0]);
            sw = ref_swap(acc_class);
            ln = ref_lane(acc_size, acc_addr[1:0]);
            if (ref_fault(acc_size, acc_addr[1:0])) begin
                chk(align_fault && !mem_valid && rd_data == 0, t, "fault/valid/rd",
                    {align_fault, mem_valid, rd_data[29:0]}, 32'h8000_0000);
            end else begin
                case (acc_size)
                    2'd0: begin eb = 4'b0001 << ln; ew = {24'd0, acc_wdata[7:0]}; end
                    2'd1: begin eb = 4'b0011 << ln;
                                ew = sw ? {16'd0, acc_wdata[7:0], acc_wdata[15:8]}
                                        : {16'd0, acc_wdata[15:0]}; end
                    default: begin eb = 4'hF; ew = sw ? bswap(acc_wdata) : acc_wdata; end
                endcase
                ew = ew << (8 * ln);
                sh = mem_rdata >> (8 * ln);
                case (acc_size)
                    2'd0:    er = {24'd0, sh[7:0]};
                    2'd1:    er = sw ? {16'd0, sh[7:0], sh[15:8]} : {16'd0, sh[15:0]};
                    default: er = sw ? bswap(sh) : sh;
                endcase
                chk(mem_valid && !align_fault, t, "issue", {mem_valid, align_fault}, 32'h2);
                chk(mem_addr == {acc_addr[AW-1:2], ln}, t, "mem_addr", mem_addr,
                    {acc_addr[AW-1:2], ln});
                chk(mem_be == eb, t, "mem_be", {28'd0, mem_be}, {28'd0, eb});
                if (acc_we) begin
                    chk(mem_we == 1'b1, t, "mem_we", {31'd0, mem_we}, 32'd1);
                    chk(mem_wdata == ew, t, "mem_wdata", mem_wdata, ew);
                    for (int i = 0; i < 4; i++)
                        if (mem_be[i]) bank[i] = mem_wdata[8*i +: 8];
                end else begin
                    chk(rd_data == er, t, "rd_data", rd_data, er);
                end
            end
        end
        @(posedge clk);
        m_cfg = m_cfg | (m_remap & m_big);
        nb = exc_entry ? m_exce : (setend_valid ? setend_big : m_big);
        if (ctl_wr && ctl_priv) begin
            m_remap = ctl_wdata[7];
            m_exce  = ctl_wdata[9];
        end
        m_big = nb;
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset(input bit strap);
        idle();
        strap_irev = strap;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_remap = 0; m_exce = 0; m_big = 0; m_cfg = 0; m_irev = strap;
    endtask

    task automatic access(input logic [1:0] cls, input logic [1:0] sz, input logic [31:0] a,
                          input bit we, input logic [31:0] wd, input logic [31:0] rd);
        acc_valid = 1; acc_class = cls; acc_size = sz; acc_addr = a;
        acc_we = we; acc_wdata = wd; mem_rdata = rd;
        cyc();
    endtask

    task automatic ctl_write(input bit priv, input bit remap, input bit exce);
        ctl_wr = 1; ctl_priv = priv;
        ctl_wdata = 32'(remap) << 7 | 32'(exce) << 9;
        cyc();
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 6) begin
                ctl_wr = 1; ctl_priv = 1'($urandom); ctl_wdata = $urandom;
            end else if (r < 12) begin
                setend_valid = 1; setend_big = 1'($urandom);
            end else if (r < 15) begin
                exc_entry = 1;
                if ($urandom_range(0, 1) == 1) begin setend_valid = 1; setend_big = 1'($urandom); end
            end
            acc_valid = ($urandom_range(0, 9) != 0);
            acc_class = 2'($urandom_range(0, 2));
            acc_size  = ($urandom_range(0, 19) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
            acc_addr  = $urandom; acc_we = 1'($urandom);
            acc_wdata = $urandom; mem_rdata = $urandom;
            cyc();
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset(1'b0);
        // R1: reset state and plain little-endian lanes
        chk(cfg_error == 0, "R1", "cfg_error after reset", {31'd0, cfg_error}, 0);
        access(2'd1, 2'd0, 32'h100, 1, 32'h0000_00AB, 0);
        access(2'd1, 2'd1, 32'h102, 0, 0, 32'hA1B2_C3D4);
        // R3: unprivileged write ignored, observed through byte lane
        ctl_write(0, 1, 0);
        access(2'd1, 2'd0, 32'h200, 1, 32'h55, 0);
        // R8: remap model, store word then byte load
        ctl_write(1, 1, 0);
        access(2'd1, 2'd2, 32'h0, 1, 32'h1234_5678, 0);
        access(2'd1, 2'd0, 32'h0, 0, 0, {bank[3], bank[2], bank[1], bank[0]});
        chk(rd_data == 32'h12, "R8", "remap byte-after-word", rd_data, 32'h12);
        // R2: fetch and walk also remapped
        access(2'd0, 2'd1, 32'h10, 0, 0, 32'hDEAD_BEEF);
        access(2'd2, 2'd0, 32'h11, 0, 0, 32'hDEAD_BEEF);
        // R9: both models on -> sticky error, remap priority
        setend_valid = 1; setend_big = 1; cyc();
        access(2'd1, 2'd2, 32'h20, 1, 32'hCAFE_F00D, 0);
        ctl_write(1, 0, 0);
        setend_valid = 1; setend_big = 0; cyc();
        cyc();
        chk(cfg_error == 1, "R9", "cfg_error still set", {31'd0, cfg_error}, 1);
        // R8 and R4 under byte reversal
        do_reset(1'b0);
        setend_valid = 1; setend_big = 1; cyc();
        access(2'd1, 2'd2, 32'h0, 1, 32'h1234_5678, 0);
        access(2'd1, 2'd0, 32'h0, 0, 0, {bank[3], bank[2], bank[1], bank[0]});
        chk(rd_data == 32'h12, "R8", "reverse byte-after-word", rd_data, 32'h12);
        access(2'd1, 2'd1, 32'h6, 1, 32'h0000_BEEF, 0);
        access(2'd0, 2'd2, 32'h8, 0, 0, 32'h0403_0201);   // R7 strap 0: fetch stays LE
        // R5: exception reload beats set-endian; R6 walk follows exception bit
        ctl_write(1, 0, 1);
        setend_valid = 1; setend_big = 1; exc_entry = 1; cyc();
        access(2'd2, 2'd2, 32'hC, 0, 0, 32'h0403_0201);
        exc_entry = 1; ctl_wr = 1; ctl_priv = 1; ctl_wdata = 0; cyc();
        access(2'd1, 2'd2, 32'hC, 0, 0, 32'h0403_0201);
        random_run(2500);
        // R7: strap 1 reverses fetches; strap ignored after reset
        do_reset(1'b1);
        strap_irev = 0;
        access(2'd0, 2'd2, 32'h40, 0, 0, 32'h1122_3344);
        strap_irev = 0;
        random_run(2500);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule